// File: doc/BRIEF.md
# Keyed Shutdown and Wake-Up Controller

This block sits in the always-on domain and runs from the slow clock. Software powers the system down by writing a keyed command to the control register. The registered `pwr_en` output then falls and stays low until an enabled wake source qualifies. Wake sources are sixteen external pins and two internal timer alarm strobes: a calendar alarm and a tick-counter alarm.

Each wake pin passes through a two-stage synchronizer. A per-pin level select then marks the pin active-high or active-low, and a debouncer requires the active level to persist for a programmable number of slow-clock cycles. All pins share one debounce length. When a wake fires, the sources that caused it are latched in a status register. Software reads that register after power returns, and the read clears it.

The register bus is a plain single-cycle strobe interface with byte offsets. Read data is registered and appears after the clock edge that samples the read strobe.

Top module: `shutdown_wake_ctrl`

## Requirements
- R1: A write to offset 0x00 whose bits 31:24 differ from 0xA5, or whose bit 0 is clear, leaves `pwr_en` high.
- R2: A write to offset 0x00 with 0xA5 in bits 31:24 and bit 0 set drives `pwr_en` low after the edge that samples it. `pwr_en` then stays low until a qualified wake.
- R3: The wake-input register at offset 0x0C holds pin enables in bits 15:0 and pin levels in bits 31:16, where 1 selects active-high and 0 selects active-low. It reads back as written. Activity on a disabled pin never wakes the system.
- R4: Mode register (offset 0x04) bits 26:24 select the debounce length: codes 0..5 give 0, 3, 32, 512, 4096 and 32768 cycles. A pin change reaches `pwr_en` on the (3+N)th edge after it is applied, where N is the selected length. The field reads back as written.
- R5: Codes 6 and 7 behave like code 5. An active run shorter than N restarts the count, so it never wakes the system.
- R6: Mode bit 17 enables the calendar alarm and bit 16 enables the tick alarm. An enabled alarm pulse while down raises `pwr_en` after the edge that samples it. A disabled alarm has no effect.
- R7: Status register (offset 0x08) bits 31:16 record the pins that woke the system, bit 5 the calendar alarm and bit 4 the tick alarm. Bits are set only by a wake while `pwr_en` is low.
- R8: Reading the status register returns its contents and clears it. After reset it reads zero.
- R9: With zero in both the mode and wake-input registers, no pin or alarm activity ends a shutdown.
- R10: Reset leaves `pwr_en` high and the mode, wake-input and status registers at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wake_pins | input | 16 | Asynchronous external wake pins |
| rtc_alarm | input | 1 | Calendar alarm strobe |
| rtt_alarm | input | 1 | Tick-counter alarm strobe |
| pwr_en | output | 1 | System power enable |

## Verification
Each result has a fixed latency. Read data is due one edge after the read strobe. The shutdown command and an alarm take effect one edge after the write or pulse. A pin needs three edges plus the debounce length. The bench drives all inputs on the falling edge and waits an exact number of falling edges before sampling `pwr_en`. For every timing case it checks both the cycle just before the expected rise, where `pwr_en` must still be low, and the cycle of the rise. A queue holds the expected read values, and a monitor compares each one on the falling edge after the read was sampled.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_MODE = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'h8;
  localparam logic [3:0] OFS_WUIR = 4'hC;
  localparam logic [7:0] SHDN_KEY = 8'hA5;

  // debounce length in slow-clock cycles for each select code
  function automatic logic [15:0] dbc_cycles(input logic [2:0] code);
    case (code)
      3'd0:    dbc_cycles = 16'd0;
      3'd1:    dbc_cycles = 16'd3;
      3'd2:    dbc_cycles = 16'd32;
      3'd3:    dbc_cycles = 16'd512;
      3'd4:    dbc_cycles = 16'd4096;
      default: dbc_cycles = 16'd32768;
    endcase
  endfunction
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q, out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      out_q  <= '0;
    end else begin
      meta_q <= d_async;
      out_q  <= meta_q;
    end
  end

  assign d_sync = out_q;
endmodule

// File: rtl/swc_pin_qual.sv
module swc_pin_qual #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl,
  input  logic             act_high,
  input  logic [CNT_W-1:0] thr,
  output logic             fire
);
  logic             active;
  logic [CNT_W-1:0] cnt_q;

  assign active = act_high ? lvl : ~lvl;

  // run length of the active level, saturating at the threshold
  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (!active)      cnt_q <= '0;
    else if (cnt_q < thr)  cnt_q <= cnt_q + 1'b1;
  end

  assign fire = active && (cnt_q >= thr);

  // R5: a nonzero length can only fire after an active cycle already counted
  p_hold_before_fire_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && thr != '0 && $stable(thr)) |-> $past(active));
endmodule

// File: rtl/shutdown_wake_ctrl.sv
module shutdown_wake_ctrl #(
  parameter int NPINS  = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  wake_pins,
  input  logic              rtc_alarm,
  input  logic              rtt_alarm,
  output logic              pwr_en
);
  import swc_pkg::*;

  localparam int LVL_LSB = DATA_W / 2;
  localparam int KEY_LSB = DATA_W - 8;
  localparam int DBC_LSB = 24;
  localparam int RTC_EN  = 17;
  localparam int RTT_EN  = 16;

  logic [2:0]       dbc_q;
  logic             rtc_en_q, rtt_en_q;
  logic [NPINS-1:0] pin_en_q, pin_hi_q;
  logic [NPINS-1:0] st_pins_q;
  logic             st_rtc_q, st_rtt_q;
  logic             pwr_q;
  logic [DATA_W-1:0] rdata_q;

  logic [NPINS-1:0] pin_sync, pin_fire, pin_hits;
  logic [CNT_W-1:0] thr;
  logic             wr_ctrl, shdn_cmd, rd_stat, rtc_hit, rtt_hit, wake;

  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign shdn_cmd = wr_ctrl && (bus_wdata[KEY_LSB +: 8] == SHDN_KEY) && bus_wdata[0];
  assign rd_stat  = bus_rd && (bus_addr == OFS_STAT);
  assign thr      = CNT_W'(dbc_cycles(dbc_q));

  swc_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .d_async(wake_pins), .d_sync(pin_sync)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    swc_pin_qual #(.CNT_W(CNT_W)) u_qual (
      .clk(clk), .rst(rst), .lvl(pin_sync[i]), .act_high(pin_hi_q[i]),
      .thr(thr), .fire(pin_fire[i])
    );
  end

  assign pin_hits = pin_fire & pin_en_q;
  assign rtc_hit  = rtc_en_q && rtc_alarm;
  assign rtt_hit  = rtt_en_q && rtt_alarm;
  assign wake     = !pwr_q && ((|pin_hits) || rtc_hit || rtt_hit);

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dbc_q    <= '0;
      rtc_en_q <= 1'b0;
      rtt_en_q <= 1'b0;
      pin_en_q <= '0;
      pin_hi_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_MODE) begin
        dbc_q    <= bus_wdata[DBC_LSB +: 3];
        rtc_en_q <= bus_wdata[RTC_EN];
        rtt_en_q <= bus_wdata[RTT_EN];
      end
      if (bus_addr == OFS_WUIR) begin
        pin_en_q <= bus_wdata[NPINS-1:0];
        pin_hi_q <= bus_wdata[LVL_LSB +: NPINS];
      end
    end
  end

  // power state
  always_ff @(posedge clk) begin
    if (rst)                  pwr_q <= 1'b1;
    else if (pwr_q && shdn_cmd) pwr_q <= 1'b0;
    else if (wake)            pwr_q <= 1'b1;
  end

  // wake cause, cleared on read; a wake in the read cycle survives
  always_ff @(posedge clk) begin
    if (rst) begin
      st_pins_q <= '0;
      st_rtc_q  <= 1'b0;
      st_rtt_q  <= 1'b0;
    end else if (rd_stat) begin
      st_pins_q <= wake ? pin_hits : '0;
      st_rtc_q  <= wake && rtc_hit;
      st_rtt_q  <= wake && rtt_hit;
    end else if (wake) begin
      st_pins_q <= st_pins_q | pin_hits;
      st_rtc_q  <= st_rtc_q | rtc_hit;
      st_rtt_q  <= st_rtt_q | rtt_hit;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_MODE: rdata_q <= {5'b0, dbc_q, 6'b0, rtc_en_q, rtt_en_q, 16'b0};
        OFS_STAT: rdata_q <= {st_pins_q, 10'b0, st_rtc_q, st_rtt_q, 4'b0};
        OFS_WUIR: rdata_q <= {pin_hi_q, pin_en_q};
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign pwr_en    = pwr_q;

  p_bad_key_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_CTRL && bus_wdata[KEY_LSB +: 8] != SHDN_KEY && pwr_en)
    |=> pwr_en);

  p_shutdown_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_CTRL && bus_wdata[KEY_LSB +: 8] == SHDN_KEY &&
     bus_wdata[0] && pwr_en) |=> !pwr_en);

  p_rise_has_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> ({st_pins_q, st_rtc_q, st_rtt_q} != '0));

  p_no_set_powered_r7: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && {st_pins_q, st_rtc_q, st_rtt_q} == '0) |=>
    ({st_pins_q, st_rtc_q, st_rtt_q} == '0));

  p_clear_on_read_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_STAT && pwr_en) |=>
    ({st_pins_q, st_rtc_q, st_rtt_q} == '0));

  p_all_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    (!pwr_en && !bus_wr && pin_en_q == '0 && !rtc_en_q && !rtt_en_q) |=> !pwr_en);
endmodule

// File: tb/shutdown_wake_ctrl_test.sv
`timescale 1ns/1ps
module shutdown_wake_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] wake_pins = 16'h0080;
  logic        rtc_alarm = 1'b0, rtt_alarm = 1'b0;
  logic        pwr_en;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  logic rd_d = 1'b0;

  always #10 clk = ~clk;

  shutdown_wake_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_pins(wake_pins),
    .rtc_alarm(rtc_alarm), .rtt_alarm(rtt_alarm), .pwr_en(pwr_en)
  );

  always @(posedge clk) rd_d <= bus_rd;

  // monitor: read data is due one edge after the strobe
  always @(negedge clk) begin
    if (rd_d) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (bus_rdata !== e.val) begin
        errors++;
        $display("FAIL %s read got %h expected %h", e.tag, bus_rdata, e.val);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.val = e; it.tag = tag;
    exp_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    tick(1);
    bus_rd = 1'b0;
  endtask

  task automatic chk_pwr(input logic e, input string tag);
    checks++;
    if (pwr_en !== e) begin
      errors++;
      $display("FAIL %s pwr_en got %b expected %b", tag, pwr_en, e);
    end
  endtask

  task automatic shut;
    wr(4'h0, 32'hA500_0001);
    chk_pwr(1'b0, "R2");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R10 reset state
    chk_pwr(1'b1, "R10");
    rd(4'h4, 32'h0, "R10");
    rd(4'hC, 32'h0, "R10");
    rd(4'h8, 32'h0, "R8");

    // R1 wrong key, missing command bit
    wr(4'h0, 32'h5A00_0001);
    chk_pwr(1'b1, "R1");
    wr(4'h0, 32'hA500_0000);
    chk_pwr(1'b1, "R1");

    // R3 pin 3 active-high, pin 7 active-low
    wr(4'hC, 32'h0008_0088);
    rd(4'hC, 32'h0008_0088, "R3");
    wr(4'h4, 32'h0);

    // R4 code 0: three edges
    shut();
    tick(5);
    chk_pwr(1'b0, "R2");
    wake_pins[3] = 1'b1;
    tick(2);
    chk_pwr(1'b0, "R4");
    tick(1);
    chk_pwr(1'b1, "R4");
    wake_pins[3] = 1'b0;
    rd(4'h8, 32'h0008_0000, "R7");
    rd(4'h8, 32'h0, "R8");

    // R4 code 2 (32 cycles) on the active-low pin
    wr(4'h4, 32'h0200_0000);
    rd(4'h4, 32'h0200_0000, "R4");
    shut();
    wake_pins[7] = 1'b0;
    tick(34);
    chk_pwr(1'b0, "R4");
    tick(1);
    chk_pwr(1'b1, "R4");
    wake_pins[7] = 1'b1;
    rd(4'h8, 32'h0080_0000, "R7");

    // R3 disabled pin, R6 disabled alarm, then calendar alarm wake
    wr(4'h4, 32'h0002_0000);
    shut();
    wake_pins[5] = 1'b1;
    tick(10);
    chk_pwr(1'b0, "R3");
    rtt_alarm = 1'b1;
    tick(1);
    rtt_alarm = 1'b0;
    tick(3);
    chk_pwr(1'b0, "R6");
    rtc_alarm = 1'b1;
    tick(1);
    rtc_alarm = 1'b0;
    chk_pwr(1'b1, "R6");
    wake_pins[5] = 1'b0;
    rd(4'h8, 32'h0000_0020, "R7");

    // R6 tick alarm wake
    wr(4'h4, 32'h0001_0000);
    shut();
    rtt_alarm = 1'b1;
    tick(1);
    rtt_alarm = 1'b0;
    chk_pwr(1'b1, "R6");
    rd(4'h8, 32'h0000_0010, "R7");

    // R7 activity while powered records nothing
    rtt_alarm = 1'b1;
    tick(1);
    rtt_alarm = 1'b0;
    wake_pins[3] = 1'b1;
    tick(5);
    wake_pins[3] = 1'b0;
    tick(4);
    chk_pwr(1'b1, "R7");
    rd(4'h8, 32'h0, "R7");

    // R5 short run restarts the count (code 1, three cycles)
    wr(4'h4, 32'h0100_0000);
    shut();
    wake_pins[3] = 1'b1;
    tick(3);
    wake_pins[3] = 1'b0;
    tick(4);
    chk_pwr(1'b0, "R5");
    wake_pins[3] = 1'b1;
    tick(5);
    chk_pwr(1'b0, "R4");
    tick(1);
    chk_pwr(1'b1, "R4");
    wake_pins[3] = 1'b0;
    rd(4'h8, 32'h0008_0000, "R7");

    // R5 code 7 acts as the longest length
    wr(4'h4, 32'h0700_0000);
    rd(4'h4, 32'h0700_0000, "R5");
    shut();
    wake_pins[3] = 1'b1;
    tick(3 + 32768 - 1);
    chk_pwr(1'b0, "R5");
    tick(1);
    chk_pwr(1'b1, "R5");
    wake_pins[3] = 1'b0;
    rd(4'h8, 32'h0008_0000, "R5");

    // R9 all sources disabled
    wr(4'h4, 32'h0);
    wr(4'hC, 32'h0);
    rd(4'h4, 32'h0, "R9");
    rd(4'hC, 32'h0, "R9");
    shut();
    wake_pins = 16'h0008;
    rtc_alarm = 1'b1;
    rtt_alarm = 1'b1;
    tick(2);
    rtc_alarm = 1'b0;
    rtt_alarm = 1'b0;
    tick(40);
    chk_pwr(1'b0, "R9");

    // R10 reset restores power
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(1);
    chk_pwr(1'b1, "R10");
    rd(4'h8, 32'h0, "R10");
    tick(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule